// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block brings a DDR SDRAM interface out of power-up once the rest of the memory controller has been configured. A single start pulse launches it. It first holds CKE low for a programmable settling period. Then it walks a fixed list of commands with programmable gaps between them. The list brings the DLL up in two phases: a mode-register write with DLL reset set, a long wait, and later the same write with DLL reset cleared. When the list is finished, the block raises `done` and the normal command scheduler can take over the bus.

Each of the two module slots reports a 3-bit page-size code, and the code 7 means the slot is empty. If both slots are empty, the sequencer does not touch the bus and flags an error. If only slot 1 is empty, its clock enable is switched off when the sequence completes, which saves power.

All timing inputs are captured when a start is accepted. A single down-counter times every wait in the sequence.

Top module: `ddr_powerup_seq`

## Requirements
- R1: After reset: `cmd`=0, `cmd_vld`=0, `mr_ext`=0, `dll_rst`=0, `cke`=0, `slot_clk_en`=2'b11, `done`=0, `no_mem_err`=0.
- R2: Command codes on `cmd` are NOP=0, precharge-all=1, mode-register write=2 and auto-refresh=3. `cmd_vld` is high for exactly the cycles that carry a command. In every other cycle `cmd` is NOP and both `mr_ext` and `dll_rst` are 0.
- R3: A start pulse is accepted in the idle state. Counting the accepting clock edge as cycle 0, `cke` rises in cycle `pwrup_cyc`+1 and the first command appears in the following cycle. No command is issued while `cke` is low, and once `cke` is high it stays high.
- R4: Exactly seven commands are issued, in this order, each shown as {cmd, mr_ext, dll_rst}:
  - precharge-all {1,0,0}
  - extended mode write enabling the DLL {2,1,0}
  - mode write with DLL reset {2,0,1}
  - precharge-all {1,0,0}
  - auto-refresh {3,0,0}
  - auto-refresh {3,0,0}
  - mode write with DLL reset cleared {2,0,0}
- R5: The gap after each command is given in NOP cycles:
  - `trp_cyc` after each precharge-all
  - `tmrd_cyc` after the extended mode write
  - `trfc_cyc` after each auto-refresh
- R6: The gap after the DLL-reset mode write is max(`dll_cyc`, MIN_DLL_WAIT) NOP cycles.
- R7: `done` rises `tmrd_cyc`+1 cycles after the final mode write. It then stays high, and no further command is issued.
- R8: If both page-size codes are 7 when start is accepted, `no_mem_err` goes high in cycle 0 and stays high. In that case `cke` stays low, no command is issued and `done` stays low.
- R9: `slot_clk_en` stays 2'b11 until `done`. When `done` rises, bit 1 drops if slot 1's code at start was 7. Bit 0 is never dropped.
- R10: A start pulse has no effect while a sequence is running, after `done`, or after `no_mem_err`.
- R11: Changes to the page-size and timing inputs after a start is accepted do not affect that sequence.
- R12: A gap value of 0 gives back-to-back commands in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| slot0_psz | input | PSZ_W | Slot 0 page-size code (7 = empty) |
| slot1_psz | input | PSZ_W | Slot 1 page-size code (7 = empty) |
| pwrup_cyc | input | CNT_W | Power-up wait before CKE, in cycles |
| dll_cyc | input | CNT_W | Wait after the DLL-reset write, in cycles (floored) |
| trp_cyc | input | DLY_W | Gap after precharge-all |
| tmrd_cyc | input | DLY_W | Gap after a mode write |
| trfc_cyc | input | DLY_W | Gap after auto-refresh |
| cmd | output | 2 | Command code |
| cmd_vld | output | 1 | Command strobe |
| mr_ext | output | 1 | Mode write targets the extended register |
| dll_rst | output | 1 | Mode write carries DLL reset |
| cke | output | 1 | Clock enable to the memory |
| slot_clk_en | output | 2 | Per-slot clock enable |
| done | output | 1 | Initialization complete |
| no_mem_err | output | 1 | Both slots empty |

## Verification
The bench keeps CNT_W=16, DLY_W=8 and PSZ_W=3, and lowers MIN_DLL_WAIT to 40. With the lower floor, a DLL wait below the floor, one exactly at it and one above it all fit in short runs. The zero-gap vector puts the power-up wait and every command gap at their lower edge. The timing vectors cover empty-slot-1, empty-slot-0 and both-populated layouts; both-empty is covered by a directed test. Another directed run changes the inputs and pulses start in the middle of the DLL wait.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_MODE = 2'd2,
    CMD_AREF = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    GAP_TRP,
    GAP_TMRD,
    GAP_DLL,
    GAP_TRFC
  } gap_e;

  typedef struct packed {
    cmd_e cmd;
    logic mr_ext;
    logic dll_rst;
    gap_e gap;
  } step_t;

  localparam int NUM_STEPS = 7;
  localparam int STEP_W    = $clog2(NUM_STEPS + 1);

  // Ordered bring-up list; the order is the behaviour.
  function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
    step_t s;
    case (idx)
      3'd0:    s = '{CMD_PREA, 1'b0, 1'b0, GAP_TRP};
      3'd1:    s = '{CMD_MODE, 1'b1, 1'b0, GAP_TMRD};
      3'd2:    s = '{CMD_MODE, 1'b0, 1'b1, GAP_DLL};
      3'd3:    s = '{CMD_PREA, 1'b0, 1'b0, GAP_TRP};
      3'd4:    s = '{CMD_AREF, 1'b0, 1'b0, GAP_TRFC};
      3'd5:    s = '{CMD_AREF, 1'b0, 1'b0, GAP_TRFC};
      3'd6:    s = '{CMD_MODE, 1'b0, 1'b0, GAP_TMRD};
      default: s = '{CMD_NOP,  1'b0, 1'b0, GAP_TMRD};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (count_q != '0) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign expired = (count_q == '0);

endmodule

// File: rtl/ddr_slot_check.sv
module ddr_slot_check #(
  parameter int PSZ_W    = 3,
  parameter int NOT_INST = 7
) (
  input  logic [PSZ_W-1:0] psz0,
  input  logic [PSZ_W-1:0] psz1,
  output logic             no_mem,
  output logic             slot1_empty
);

  localparam logic [PSZ_W-1:0] EMPTY_CODE = PSZ_W'(NOT_INST);

  logic slot0_empty;

  assign slot0_empty = (psz0 == EMPTY_CODE);
  assign slot1_empty = (psz1 == EMPTY_CODE);
  assign no_mem      = slot0_empty && slot1_empty;

endmodule

// File: rtl/ddr_gap_select.sv
module ddr_gap_select
  import ddr_init_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int DLY_W        = 8,
  parameter int MIN_DLL_WAIT = 200
) (
  input  gap_e             sel,
  input  logic [DLY_W-1:0] trp,
  input  logic [DLY_W-1:0] tmrd,
  input  logic [DLY_W-1:0] trfc,
  input  logic [CNT_W-1:0] dll_wait,
  output logic [CNT_W-1:0] gap_cyc
);

  localparam logic [CNT_W-1:0] DLL_FLOOR = CNT_W'(MIN_DLL_WAIT);

  logic [CNT_W-1:0] dll_eff;

  generate
    if (MIN_DLL_WAIT > 0) begin : g_floor
      assign dll_eff = (dll_wait < DLL_FLOOR) ? DLL_FLOOR : dll_wait;
    end else begin : g_nofloor
      assign dll_eff = dll_wait;
    end
  endgenerate

  always_comb begin
    case (sel)
      GAP_TRP:  gap_cyc = CNT_W'(trp);
      GAP_TMRD: gap_cyc = CNT_W'(tmrd);
      GAP_DLL:  gap_cyc = dll_eff;
      default:  gap_cyc = CNT_W'(trfc);
    endcase
  end

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       no_mem,
  input  logic       slot1_empty,
  input  logic       tmr_expired,
  output logic       accept,
  output logic       tmr_load,
  output logic       load_pwr,
  output gap_e       gap_sel,
  output logic [1:0] cmd,
  output logic       cmd_vld,
  output logic       mr_ext,
  output logic       dll_rst,
  output logic       cke,
  output logic [1:0] slot_clk_en,
  output logic       done,
  output logic       no_mem_err
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_GAP,
    ST_DONE,
    ST_NOMEM
  } state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic              slot1_gate_q;
  step_t             cur_step;
  logic              last_step;

  always_comb begin
    cur_step  = step_lookup(step_q);
    last_step = (step_q == STEP_W'(NUM_STEPS));
  end

  assign accept   = (state_q == ST_IDLE) && start && !no_mem;
  assign load_pwr = (state_q == ST_IDLE);
  assign tmr_load = accept || ((state_q == ST_GAP) && tmr_expired && !last_step);
  assign gap_sel  = cur_step.gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      slot1_gate_q <= 1'b0;
      cmd          <= CMD_NOP;
      cmd_vld      <= 1'b0;
      mr_ext       <= 1'b0;
      dll_rst      <= 1'b0;
      cke          <= 1'b0;
      slot_clk_en  <= 2'b11;
      done         <= 1'b0;
      no_mem_err   <= 1'b0;
    end else begin
      cmd     <= CMD_NOP;
      cmd_vld <= 1'b0;
      mr_ext  <= 1'b0;
      dll_rst <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (no_mem) begin
              no_mem_err <= 1'b1;
              state_q    <= ST_NOMEM;
            end else begin
              slot1_gate_q <= slot1_empty;
              state_q      <= ST_PWRUP;
            end
          end
        end
        ST_PWRUP: begin
          if (tmr_expired) begin
            cke     <= 1'b1;
            step_q  <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_expired) begin
            if (last_step) begin
              done           <= 1'b1;
              slot_clk_en[1] <= !slot1_gate_q;
              state_q        <= ST_DONE;
            end else begin
              cmd     <= cur_step.cmd;
              cmd_vld <= 1'b1;
              mr_ext  <= cur_step.mr_ext;
              dll_rst <= cur_step.dll_rst;
              step_q  <= step_q + 1'b1;
            end
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
  import ddr_init_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int DLY_W        = 8,
  parameter int PSZ_W        = 3,
  parameter int NOT_INST     = 7,
  parameter int MIN_DLL_WAIT = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PSZ_W-1:0] slot0_psz,
  input  logic [PSZ_W-1:0] slot1_psz,
  input  logic [CNT_W-1:0] pwrup_cyc,
  input  logic [CNT_W-1:0] dll_cyc,
  input  logic [DLY_W-1:0] trp_cyc,
  input  logic [DLY_W-1:0] tmrd_cyc,
  input  logic [DLY_W-1:0] trfc_cyc,
  output logic [1:0]       cmd,
  output logic             cmd_vld,
  output logic             mr_ext,
  output logic             dll_rst,
  output logic             cke,
  output logic [1:0]       slot_clk_en,
  output logic             done,
  output logic             no_mem_err
);

  logic             no_mem;
  logic             slot1_empty;
  logic             accept;
  logic             tmr_load;
  logic             load_pwr;
  logic             tmr_expired;
  gap_e             gap_sel;
  logic [CNT_W-1:0] gap_cyc;
  logic [CNT_W-1:0] tmr_val;

  logic [CNT_W-1:0] dll_q;
  logic [DLY_W-1:0] trp_q;
  logic [DLY_W-1:0] tmrd_q;
  logic [DLY_W-1:0] trfc_q;

  // Timing set is frozen for the whole run once a start is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      dll_q  <= '0;
      trp_q  <= '0;
      tmrd_q <= '0;
      trfc_q <= '0;
    end else if (accept) begin
      dll_q  <= dll_cyc;
      trp_q  <= trp_cyc;
      tmrd_q <= tmrd_cyc;
      trfc_q <= trfc_cyc;
    end
  end

  ddr_slot_check #(
    .PSZ_W   (PSZ_W),
    .NOT_INST(NOT_INST)
  ) i_slot_check (
    .psz0       (slot0_psz),
    .psz1       (slot1_psz),
    .no_mem     (no_mem),
    .slot1_empty(slot1_empty)
  );

  ddr_gap_select #(
    .CNT_W       (CNT_W),
    .DLY_W       (DLY_W),
    .MIN_DLL_WAIT(MIN_DLL_WAIT)
  ) i_gap_select (
    .sel     (gap_sel),
    .trp     (trp_q),
    .tmrd    (tmrd_q),
    .trfc    (trfc_q),
    .dll_wait(dll_q),
    .gap_cyc (gap_cyc)
  );

  assign tmr_val = load_pwr ? pwrup_cyc : gap_cyc;

  ddr_wait_timer #(
    .CNT_W(CNT_W)
  ) i_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  ddr_init_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .no_mem     (no_mem),
    .slot1_empty(slot1_empty),
    .tmr_expired(tmr_expired),
    .accept     (accept),
    .tmr_load   (tmr_load),
    .load_pwr   (load_pwr),
    .gap_sel    (gap_sel),
    .cmd        (cmd),
    .cmd_vld    (cmd_vld),
    .mr_ext     (mr_ext),
    .dll_rst    (dll_rst),
    .cke        (cke),
    .slot_clk_en(slot_clk_en),
    .done       (done),
    .no_mem_err (no_mem_err)
  );

endmodule

// File: rtl/ddr_powerup_seq_chk.sv
module ddr_powerup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cmd,
  input logic       cmd_vld,
  input logic       mr_ext,
  input logic       dll_rst,
  input logic       cke,
  input logic [1:0] slot_clk_en,
  input logic       done,
  input logic       no_mem_err
);

  AST_NOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld |-> (cmd == 2'd0) && !mr_ext && !dll_rst); // R2

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> cke); // R3

  AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke); // R3

  AST_DLL_ON_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dll_rst |-> cmd_vld && (cmd == 2'd2) && !mr_ext); // R4

  AST_DONE_STICKY_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !cmd_vld); // R7

  AST_NOMEM_SILENT: assert property (@(posedge clk) disable iff (rst)
    no_mem_err |-> !cmd_vld && !cke && !done); // R8

  AST_CLKS_ON_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    !done |-> (slot_clk_en == 2'b11)); // R9

endmodule

bind ddr_powerup_seq ddr_powerup_seq_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd        (cmd),
  .cmd_vld    (cmd_vld),
  .mr_ext     (mr_ext),
  .dll_rst    (dll_rst),
  .cke        (cke),
  .slot_clk_en(slot_clk_en),
  .done       (done),
  .no_mem_err (no_mem_err)
);

// File: tb/test_ddr_powerup_seq.sv
`timescale 1ns/1ps
module test_ddr_powerup_seq;

  localparam int CNT_W     = 16;
  localparam int DLY_W     = 8;
  localparam int PSZ_W     = 3;
  localparam int MIN_DW    = 40;
  localparam int NVEC      = 4;
  localparam int RUN_LIMIT = 3000;

  // {pwrup, dll, trp, tmrd, trfc, psz0, psz1}
  localparam logic [61:0] VEC [NVEC] = '{
    {16'd10, 16'd5,   8'd2, 8'd1, 8'd4, 3'd2, 3'd3},
    {16'd0,  16'd250, 8'd0, 8'd0, 8'd0, 3'd0, 3'd7},
    {16'd30, 16'd40,  8'd3, 8'd2, 8'd9, 3'd7, 3'd1},
    {16'd5,  16'd0,   8'd1, 8'd3, 8'd1, 3'd5, 3'd6}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [PSZ_W-1:0] slot0_psz = '0;
  logic [PSZ_W-1:0] slot1_psz = '0;
  logic [CNT_W-1:0] pwrup_cyc = '0;
  logic [CNT_W-1:0] dll_cyc = '0;
  logic [DLY_W-1:0] trp_cyc = '0;
  logic [DLY_W-1:0] tmrd_cyc = '0;
  logic [DLY_W-1:0] trfc_cyc = '0;
  logic [1:0]       cmd;
  logic             cmd_vld;
  logic             mr_ext;
  logic             dll_rst;
  logic             cke;
  logic [1:0]       slot_clk_en;
  logic             done;
  logic             no_mem_err;

  int errors = 0;
  int checks = 0;
  int cyc_total = 0;

  always #5 clk = ~clk;

  ddr_powerup_seq #(
    .CNT_W       (CNT_W),
    .DLY_W       (DLY_W),
    .PSZ_W       (PSZ_W),
    .MIN_DLL_WAIT(MIN_DW)
  ) i_ddr_powerup_seq (
    .clk(clk), .rst(rst), .start(start),
    .slot0_psz(slot0_psz), .slot1_psz(slot1_psz),
    .pwrup_cyc(pwrup_cyc), .dll_cyc(dll_cyc),
    .trp_cyc(trp_cyc), .tmrd_cyc(tmrd_cyc), .trfc_cyc(trfc_cyc),
    .cmd(cmd), .cmd_vld(cmd_vld), .mr_ext(mr_ext), .dll_rst(dll_rst),
    .cke(cke), .slot_clk_en(slot_clk_en), .done(done), .no_mem_err(no_mem_err)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst   = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_seq(input int p, input int dw, input int trp, input int tmrd,
                         input int trfc, input int psz0, input int psz1, input bit disturb);
    int cmd_cyc[8];
    int cmd_val[8];
    int exp_cyc[7];
    int exp_val[7];
    int gaps[7];
    int ncmd = 0;
    int cke_cyc = -1;
    int done_cyc = -1;
    int dwe;
    int late;
    string tag;
    do_reset();
    slot0_psz = PSZ_W'(psz0);
    slot1_psz = PSZ_W'(psz1);
    pwrup_cyc = CNT_W'(p);
    dll_cyc   = CNT_W'(dw);
    trp_cyc   = DLY_W'(trp);
    tmrd_cyc  = DLY_W'(tmrd);
    trfc_cyc  = DLY_W'(trfc);
    start     = 1'b1;
    for (int n = 0; n < RUN_LIMIT && done_cyc < 0; n++) begin
      @(negedge clk);
      if (n == 0) start = 1'b0;
      if (disturb && n == 20) begin
        start = 1'b1; slot1_psz = 3'd7; trp_cyc = 8'd50; dll_cyc = 16'd0;
      end
      if (disturb && n == 21) start = 1'b0;
      if (cke && cke_cyc < 0) cke_cyc = n;
      if (cmd_vld) begin
        if (ncmd < 8) begin
          cmd_cyc[ncmd] = n;
          cmd_val[ncmd] = {28'd0, cmd, mr_ext, dll_rst};
        end
        ncmd++;
      end
      if (done) done_cyc = n;
    end
    dwe  = (dw < MIN_DW) ? MIN_DW : dw;
    gaps = '{trp, tmrd, dwe, trp, trfc, trfc, tmrd};
    exp_val = '{4, 10, 9, 4, 12, 12, 8};
    exp_cyc[0] = p + 2;
    for (int i = 1; i < 7; i++) exp_cyc[i] = exp_cyc[i-1] + gaps[i-1] + 1;
    chk("R3", "cke rise cycle", cke_cyc, p + 1);
    chk("R4", "command count", ncmd, 7);
    for (int i = 0; i < 7 && i < ncmd; i++) begin
      chk("R4", $sformatf("cmd %0d {code,ext,dll}", i), cmd_val[i], exp_val[i]);
      if (i == 0)                tag = "R3";
      else if (i == 3)           tag = "R6";
      else if (gaps[i-1] == 0)   tag = "R12";
      else                       tag = "R5";
      chk(tag, $sformatf("cmd %0d cycle", i), cmd_cyc[i], exp_cyc[i]);
    end
    chk("R7", "done cycle", done_cyc, exp_cyc[6] + tmrd + 1);
    chk("R9", "slot clocks after done", int'(slot_clk_en), (psz1 == 7) ? 1 : 3);
    if (disturb) chk("R11", "slot1 clock kept despite late code", int'(slot_clk_en), 3);
    // start after done must do nothing
    slot1_psz = PSZ_W'(psz1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    late = 0;
    repeat (40) begin
      @(negedge clk);
      if (cmd_vld) late++;
    end
    chk("R10", "commands after restart at done", late, 0);
    chk("R10", "done held after restart", int'(done), 1);
  endtask

  initial begin
    int quiet;
    // reset state
    do_reset();
    chk("R1", "cmd", int'(cmd), 0);
    chk("R1", "cmd_vld", int'(cmd_vld), 0);
    chk("R1", "mr_ext/dll_rst", int'({mr_ext, dll_rst}), 0);
    chk("R1", "cke", int'(cke), 0);
    chk("R1", "slot_clk_en", int'(slot_clk_en), 3);
    chk("R1", "done/no_mem_err", int'({done, no_mem_err}), 0);

    // table-driven sequences
    for (int v = 0; v < NVEC; v++) begin
      run_seq(int'(VEC[v][61:46]), int'(VEC[v][45:30]), int'(VEC[v][29:22]),
              int'(VEC[v][21:14]), int'(VEC[v][13:6]), int'(VEC[v][5:3]),
              int'(VEC[v][2:0]), 1'b0);
    end

    // start and input changes during the DLL wait (R10, R11)
    run_seq(4, 60, 1, 2, 3, 1, 2, 1'b1);

    // both slots empty
    do_reset();
    slot0_psz = 3'd7;
    slot1_psz = 3'd7;
    pwrup_cyc = 16'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "no_mem_err in cycle 0", int'(no_mem_err), 1);
    quiet = 0;
    repeat (300) begin
      @(negedge clk);
      if (cmd_vld || cke || done) quiet++;
    end
    chk("R8", "bus activity with no memory", quiet, 0);
    slot0_psz = 3'd1;
    slot1_psz = 3'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    quiet = 0;
    repeat (100) begin
      @(negedge clk);
      if (cmd_vld || cke) quiet++;
    end
    chk("R10", "activity after restart at error", quiet, 0);
    chk("R8", "no_mem_err held", int'(no_mem_err), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule